// File: doc/BRIEF.md
# ADC Scan Result Readback Buffer

This block holds the results of one converter scan and hands them to a serial-bus read engine one byte at a time. During a scan, the converter pushes up to `N_MAX` results of `RES_W` bits each, in the order they were converted. Before a new scan loads its results, a write-start pulse empties the buffer. Results from an earlier scan therefore can never be read back.

The read engine starts a transfer with a read-start pulse. It then takes bytes over a valid/ack handshake. Each result goes out as two bytes. The upper byte comes first and carries padding ones above the result's most significant bits. The lower byte carries the least significant eight bits. After the lower byte of the last stored result, reading wraps to the upper byte of the first result. A not-acknowledge ends the transfer. The stored results stay in place until the next scan replaces them.

Bit-level bus timing, start and stop detection, and address matching are handled outside this block.

Top module: `adc_scan_buffer`

## Requirements
- R1: After reset, `count` is 0 and `rd_valid` is low.
- R2: A `wr_en` cycle with `count` below `N_MAX` stores `wr_data` in slot `count`, and `count` rises by one on the next cycle.
- R3: A `wr_en` cycle with `count` equal to `N_MAX` changes nothing: `count` stays the same and the stored results are read back unchanged.
- R4: A `wr_start` cycle sets `count` to 0 on the next cycle. A `wr_en` in the same cycle is dropped.
- R5: The first byte of each result has bits 7..2 all ones and bits 1..0 equal to result bits 9..8. The second byte equals result bits 7..0. The upper byte is always presented before the lower byte.
- R6: Each `rd_ack` while `rd_valid` is high advances to the next byte. Results come out in the order they were written.
- R7: `rd_wrap` is high exactly while the lower byte of the last stored result is presented. The next ack returns to the upper byte of result 0.
- R8: After a new scan stores fewer results than the one before it, reading wraps at the new count. No older result appears.
- R9: A `rd_start` cycle makes the next presented byte the upper byte of result 0. This holds whatever byte was current before.
- R10: After a `rd_nack` cycle, `rd_valid` stays low until the next `rd_start`. The stored results are still readable after that `rd_start`.
- R11: While `count` is 0, `rd_valid` stays low, even during an active transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_start | input | 1 | Pulse that empties the buffer before a scan |
| wr_en | input | 1 | Store one conversion result |
| wr_data | input | RES_W | Conversion result to store |
| rd_start | input | 1 | Begin a read transfer at result 0, upper byte |
| rd_ack | input | 1 | Master acknowledged the presented byte |
| rd_nack | input | 1 | Master refused a byte; the transfer ends |
| rd_valid | output | 1 | A byte is presented |
| rd_byte | output | 8 | Presented byte |
| rd_wrap | output | 1 | Presented byte is the last byte before the wrap |
| count | output | $clog2(N_MAX+1) | Number of results stored |

## Verification
Every scan length from one result to `N_MAX` is filled with data that is a fixed arithmetic function of index and length. Each scan is read for two bytes beyond one full pass. This shows whether the wrap point follows the count and whether upper and lower bytes are swapped or mis-padded. A long scan followed by a short one separates a wrap driven by the current count from one that reaches stale slots. Overfilling, a write together with `wr_start`, a mid-stream `rd_start`, a nack and an empty buffer each probe one control path on its own.

// File: rtl/adc_scan_buffer.sv
module adc_scan_buffer #(
  parameter int N_MAX = 12,
  parameter int RES_W = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_start,
  input  logic                       wr_en,
  input  logic [RES_W-1:0]           wr_data,
  input  logic                       rd_start,
  input  logic                       rd_ack,
  input  logic                       rd_nack,
  output logic                       rd_valid,
  output logic [7:0]                 rd_byte,
  output logic                       rd_wrap,
  output logic [$clog2(N_MAX+1)-1:0] count
);
  localparam int CW = $clog2(N_MAX + 1);
  localparam int AW = (N_MAX > 1) ? $clog2(N_MAX) : 1;
  localparam int PAD = 16 - RES_W;

  logic [RES_W-1:0] mem [N_MAX];
  logic [CW-1:0]    rptr;
  logic             phase;
  logic             active;
  logic [15:0]      word;

  wire last = (rptr + CW'(1)) >= count;

  assign word     = {{PAD{1'b1}}, mem[rptr[AW-1:0]]};
  assign rd_valid = active && (count != '0) && (rptr < count);
  assign rd_byte  = phase ? word[7:0] : word[15:8];
  assign rd_wrap  = rd_valid && phase && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
    end else if (wr_start) begin
      count <= '0;
    end else if (wr_en && count < CW'(N_MAX)) begin
      count <= count + CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && !wr_start && wr_en && count < CW'(N_MAX))
      mem[count[AW-1:0]] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rptr   <= '0;
      phase  <= 1'b0;
    end else if (rd_start) begin
      active <= 1'b1;
      rptr   <= '0;
      phase  <= 1'b0;
    end else if (rd_nack) begin
      active <= 1'b0;
    end else if (rd_ack && rd_valid) begin
      phase <= ~phase;
      if (phase) rptr <= last ? '0 : rptr + CW'(1);
    end
  end
endmodule

// File: rtl/adc_scan_buffer_chk.sv
module adc_scan_buffer_chk #(
  parameter int N_MAX = 12,
  parameter int RES_W = 10
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       wr_start,
  input logic                       wr_en,
  input logic                       rd_start,
  input logic                       rd_nack,
  input logic                       rd_valid,
  input logic [7:0]                 rd_byte,
  input logic                       rd_wrap,
  input logic [$clog2(N_MAX+1)-1:0] count
);
  localparam int CW = $clog2(N_MAX + 1);

  p_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(N_MAX));

  p_full_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_start && count == CW'(N_MAX)) |=> count == CW'(N_MAX));

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> count == '0);

  p_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_start && count < CW'(N_MAX)) |=> count == $past(count) + CW'(1));

  p_empty_r11: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 |-> !rd_valid);

  p_nack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_nack && !rd_start) |=> !rd_valid);

  p_start_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !wr_start && count != '0) |=> (rd_valid && rd_byte[7:2] == 6'h3F && !rd_wrap));

  p_wrap_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_wrap |-> rd_valid);
endmodule

bind adc_scan_buffer adc_scan_buffer_chk #(.N_MAX(N_MAX), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_en(wr_en),
  .rd_start(rd_start), .rd_nack(rd_nack), .rd_valid(rd_valid),
  .rd_byte(rd_byte), .rd_wrap(rd_wrap), .count(count)
);

// File: tb/adc_scan_buffer_test.sv
`timescale 1ns/1ps
module adc_scan_buffer_test;
  localparam int N = 12;

  logic clk = 0, rst_n = 0;
  logic wr_start = 0, wr_en = 0, rd_start = 0, rd_ack = 0, rd_nack = 0;
  logic [9:0] wr_data = '0;
  logic rd_valid, rd_wrap;
  logic [7:0] rd_byte;
  logic [3:0] count;
  int checks = 0, errors = 0;

  adc_scan_buffer #(.N_MAX(N), .RES_W(10)) uut (
    .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_en(wr_en),
    .wr_data(wr_data), .rd_start(rd_start), .rd_ack(rd_ack), .rd_nack(rd_nack),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .rd_wrap(rd_wrap), .count(count)
  );

  always #2.5 clk = ~clk;

  function automatic logic [9:0] val(int i, int n);
    return 10'((i * 97 + n * 31 + 5) & 10'h3FF);
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic load(int n, int tag);
    wr_start = 1; step(); wr_start = 0;
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = val(i, tag); step();
    end
    wr_en = 0;
  endtask

  task automatic read_pass(int n, int tag, int nbytes, string req);
    rd_start = 1; step(); rd_start = 0;
    for (int k = 0; k < nbytes; k++) begin
      int r = (k / 2) % n;
      int hi = (k % 2) == 0;
      int eb = hi ? (32'hFC | (val(r, tag) >> 8)) : (val(r, tag) & 32'hFF);
      chk(req, rd_valid, 1);
      chk(req, rd_byte, eb);
      chk("R7", rd_wrap, (!hi && r == n - 1) ? 1 : 0);
      rd_ack = 1; step(); rd_ack = 0;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    chk("R1", count, 0); chk("R1", rd_valid, 0);
    rst_n = 1; step();
    chk("R1", count, 0); chk("R1", rd_valid, 0);

    for (int n = 1; n <= N; n++) begin
      load(n, n);
      chk("R2", count, n);
      read_pass(n, n, 2 * n + 2, "R5 R6");
    end

    load(N, 50);
    wr_en = 1; wr_data = 10'h155; step(); wr_en = 0;
    chk("R3", count, N);
    read_pass(N, 50, 2 * N, "R3");

    load(3, 60);
    chk("R8", count, 3);
    read_pass(3, 60, 10, "R8");

    wr_start = 1; wr_en = 1; wr_data = 10'h3FF; step();
    wr_start = 0; wr_en = 0;
    chk("R4", count, 0);
    rd_start = 1; step(); rd_start = 0;
    chk("R11", rd_valid, 0);
    rd_ack = 1; step(); rd_ack = 0;
    chk("R11", rd_valid, 0);

    load(4, 70);
    read_pass(4, 70, 5, "R6");
    read_pass(4, 70, 2, "R9");

    rd_nack = 1; step(); rd_nack = 0;
    chk("R10", rd_valid, 0);
    rd_ack = 1; step(); rd_ack = 0;
    chk("R10", rd_valid, 0);
    read_pass(4, 70, 8, "R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule